// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer with Selectable Ordering

This block drives the address of a four-beat burst. When either of two start strobes is high at a clock edge, it captures the incoming address. It also captures the ordering mode and clears its beat count. The strobes arrive already qualified by surrounding logic. On every later edge where the active-low step input is low, the beat count moves forward by one. The two low address bits then follow the burst order picked at load time.

In interleaved order, the low bits are the captured start bits XOR the beat count. In linear order, they are the start bits plus the beat count, modulo four. The upper address bits are held exactly as captured for the whole burst. The count wraps, so a fifth beat returns to the start address. Memory storage and strobe qualification sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` is all zeros and `beat` is 0.
- R2: A rising edge with `start_a` or `start_b` high loads `addr_out` with `addr_in` and sets `beat` to 0, both visible after that edge.
- R3: On an edge where a start strobe is high, `step_n` has no effect: `beat` is 0 and `addr_out` equals `addr_in` after the edge.
- R4: On an edge with no start strobe and `step_n` low, `beat` increases by one modulo four.
- R5: On an edge with no start strobe and `step_n` high, `addr_out` and `beat` keep their values.
- R6: With interleaved order captured (`order_lin` = 0 at load), `addr_out[1:0]` equals the captured start bits XOR `beat`. Start 01 gives 01, 00, 11, 10.
- R7: With linear order captured (`order_lin` = 1 at load), `addr_out[1:0]` equals the captured start bits plus `beat`, modulo four. Start 10 gives 10, 11, 00, 01.
- R8: A fourth advance after a load brings `addr_out[1:0]` back to the captured start bits.
- R9: The ordering mode is sampled only on a load edge. Changing `order_lin` during a burst does not change the sequence.
- R10: `addr_out[ADDR_W-1:2]` equals the upper bits of `addr_in` captured at the last load, and stays unchanged until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| start_a | input | 1 | Qualified start strobe from the first requester |
| start_b | input | 1 | Qualified start strobe from the second requester |
| step_n | input | 1 | Active-low advance to the next beat |
| order_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr_in | input | ADDR_W | Start address of an access |
| addr_out | output | ADDR_W | Sequenced address: held upper bits plus ordered low bits |
| beat | output | 2 | Beat index within the burst, 0 after a load |

## Verification
The properties take the strobes as already qualified. Either strobe alone, or both together, counts as a load. They also take `step_n` and `order_lin` as clean, synchronous levels that may change on any cycle, including in the middle of a burst. The stimulus changes every input only at the falling clock edge. It uses random strobe densities that leave long runs of stepping, so wrap-around is reached in both orders. It also flips `order_lin` freely between loads, which exercises the sampling rule.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Ordering of the low address bits within one burst.
  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_order_e;

endpackage : burst_pkg

// File: rtl/burst_start_reg.sv
// Holds the start context of a burst: low start bits, upper bits, order.
module burst_start_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  addr_in,
  input  burst_order_e       order_in,
  output logic [CNT_W-1:0]   base_o,
  output logic [ADDR_W-CNT_W-1:0] upper_o,
  output burst_order_e       order_o
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0] base_q, base_d;
  logic [UP_W-1:0]  upper_q, upper_d;
  burst_order_e     order_q, order_d;

  // Next-state: capture on load only.
  always_comb begin
    base_d  = base_q;
    upper_d = upper_q;
    order_d = order_q;
    if (load) begin
      base_d  = addr_in[CNT_W-1:0];
      upper_d = addr_in[ADDR_W-1:CNT_W];
      order_d = order_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      upper_q <= '0;
      order_q <= ORD_INTLV;
    end else if (load) begin
      base_q  <= base_d;
      upper_q <= upper_d;
      order_q <= order_d;
    end
  end

  assign base_o  = base_q;
  assign upper_o = upper_q;
  assign order_o = order_q;

endmodule : burst_start_reg

// File: rtl/burst_beat_ctr.sv
// Wrapping beat counter: cleared on load, stepped on advance.
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clear | advance;

  always_comb begin
    if (clear) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule : burst_beat_ctr

// File: rtl/burst_seq_map.sv
// Maps start bits and beat count onto the burst's low address bits.
module burst_seq_map
  import burst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base,
  input  logic [CNT_W-1:0] cnt,
  input  burst_order_e     order,
  output logic [CNT_W-1:0] low_o
);

  logic [CNT_W-1:0] intlv_v;
  logic [CNT_W-1:0] lin_v;
  logic [CNT_W:0]   carry;

  // Interleaved: bitwise toggle of the start bits by the count.
  // Linear: ripple add of the count, carry out dropped (wrap).
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    assign intlv_v[i]  = base[i] ^ cnt[i];
    assign lin_v[i]    = base[i] ^ cnt[i] ^ carry[i];
    assign carry[i+1]  = (base[i] & cnt[i]) | (carry[i] & (base[i] ^ cnt[i]));
  end

  always_comb begin
    unique case (order)
      ORD_LINEAR: low_o = lin_v;
      default:    low_o = intlv_v;
    endcase
  end

  logic unused_carry;
  assign unused_carry = carry[CNT_W];

endmodule : burst_seq_map

// File: rtl/burst_addr_seq.sv
// Top: burst address sequencer with selectable ordering.
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_a,
  input  logic              start_b,
  input  logic              step_n,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  beat
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic             load;
  logic             advance;
  logic [CNT_W-1:0] base_w;
  logic [UP_W-1:0]  upper_w;
  burst_order_e     order_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] low_w;

  // A start wins over an advance on the same edge.
  assign load    = start_a | start_b;
  assign advance = ~load & ~step_n;

  burst_start_reg #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .addr_in  (addr_in),
    .order_in (burst_order_e'(order_lin)),
    .base_o   (base_w),
    .upper_o  (upper_w),
    .order_o  (order_w)
  );

  burst_beat_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .advance (advance),
    .cnt_o   (cnt_w)
  );

  burst_seq_map #(
    .CNT_W (CNT_W)
  ) u_map (
    .base  (base_w),
    .cnt   (cnt_w),
    .order (order_w),
    .low_o (low_w)
  );

  assign addr_out = {upper_w, low_w};
  assign beat     = cnt_w;

endmodule : burst_addr_seq

// File: rtl/burst_addr_seq_chk.sv
// Port-level checker for burst_addr_seq, attached through bind.
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_a,
  input logic              start_b,
  input logic              step_n,
  input logic              order_lin,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CNT_W-1:0]  beat
);

  logic             ld;
  logic [CNT_W-1:0] chk_base;
  logic             chk_lin;

  assign ld = start_a | start_b;

  // Observer copy of the start bits and order, taken at the ports.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_base <= '0;
      chk_lin  <= 1'b0;
    end else if (ld) begin
      chk_base <= addr_in[CNT_W-1:0];
      chk_lin  <= order_lin;
    end
  end

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (addr_out == '0 && beat == '0);
    end
  end

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (addr_out == $past(addr_in) && beat == '0));

  a_r3_load_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !step_n) |=> beat == '0);

  a_r4_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !step_n) |=> beat == CNT_W'($past(beat) + 1'b1));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && step_n) |=> ($stable(beat) && $stable(addr_out)));

  a_r6_interleaved_map: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_lin |-> addr_out[CNT_W-1:0] == (chk_base ^ beat));

  a_r7_linear_map: assert property (@(posedge clk) disable iff (!rst_n)
    chk_lin |-> addr_out[CNT_W-1:0] == CNT_W'(chk_base + beat));

  a_r10_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(addr_out[ADDR_W-1:CNT_W]));

endmodule : burst_addr_seq_chk

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_a   (start_a),
  .start_b   (start_b),
  .step_n    (step_n),
  .order_lin (order_lin),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .beat      (beat)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

  localparam int AW = 17;
  localparam int CW = 2;

  logic          clk;
  logic          rst_n;
  logic          start_a, start_b, step_n, order_lin;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] beat;

  int unsigned n_chk;
  int unsigned n_fail;
  bit          done;

  // Bench reference state
  logic [CW-1:0]    m_base;
  logic [AW-CW-1:0] m_up;
  logic             m_lin;
  logic [CW-1:0]    m_cnt;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_a   (start_a),
    .start_b   (start_b),
    .step_n    (step_n),
    .order_lin (order_lin),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .beat      (beat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [CW-1:0] exp_low();
    if (m_lin) return CW'(m_base + m_cnt);
    return m_base ^ m_cnt;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic cycle(bit sa, bit sb, bit sn, bit ol, logic [AW-1:0] ai);
    string t_low, t_beat;
    start_a = sa; start_b = sb; step_n = sn; order_lin = ol; addr_in = ai;
    if (sa || sb) begin
      m_base = ai[CW-1:0]; m_up = ai[AW-1:CW]; m_lin = ol; m_cnt = '0;
      t_low  = sn ? "R2" : "R3";
      t_beat = t_low;
    end else begin
      if (!sn) m_cnt = m_cnt + 1'b1;
      t_low  = m_lin ? "R7" : "R6";
      t_beat = sn ? "R5" : "R4";
    end
    @(posedge clk);
    @(negedge clk);
    check(t_low, 32'(addr_out[CW-1:0]), 32'(exp_low()));
    check(t_beat, 32'(beat), 32'(m_cnt));
    check("R10", 32'(addr_out[AW-1:CW]), 32'(m_up));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] a;
    int unsigned   seed;
    n_chk = 0; n_fail = 0; done = 0;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    start_a = 0; start_b = 0; step_n = 1; order_lin = 0; addr_in = '1;
    m_base = '0; m_up = '0; m_lin = 0; m_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1", 32'(addr_out), 32'd0);
    check("R1", 32'(beat), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R8: interleaved from every start value, then wrap
    for (int s = 0; s < 4; s++) begin
      a = {15'($urandom), 2'(s)};
      cycle(1, 0, 1, 0, a);
      for (int k = 0; k < 4; k++) cycle(0, 0, 0, 0, '0);
      check("R8", 32'(addr_out[CW-1:0]), 32'(s));
    end
    // R6 literal: start 01 -> 01,00,11,10
    cycle(0, 1, 1, 0, 17'h1);
    cycle(0, 0, 0, 1, '0);
    check("R6", 32'(addr_out[1:0]), 32'h0);
    cycle(0, 0, 0, 1, '0);
    check("R6", 32'(addr_out[1:0]), 32'h3);
    cycle(0, 0, 0, 1, '0);
    check("R6", 32'(addr_out[1:0]), 32'h2);

    // R7 literal: start 10 -> 10,11,00,01, then R8 wrap
    cycle(1, 0, 1, 1, 17'h0ABCE);
    cycle(0, 0, 0, 0, '0);
    check("R7", 32'(addr_out[1:0]), 32'h3);
    cycle(0, 0, 0, 0, '0);
    check("R7", 32'(addr_out[1:0]), 32'h0);
    cycle(0, 0, 0, 0, '0);
    check("R7", 32'(addr_out[1:0]), 32'h1);
    cycle(0, 0, 0, 0, '0);
    check("R8", 32'(addr_out[1:0]), 32'h2);

    // R9: load linear at 01, flip order input mid-burst
    cycle(1, 0, 1, 1, 17'h00011);
    cycle(0, 0, 0, 0, '0);
    check("R9", 32'(addr_out[1:0]), 32'h2);
    // R9: load interleaved at 01, drive linear mid-burst
    cycle(0, 1, 1, 0, 17'h00011);
    cycle(0, 0, 0, 1, '0);
    check("R9", 32'(addr_out[1:0]), 32'h0);

    // R3: load with step low, both strobes together
    cycle(1, 1, 0, 0, 17'h1F00F);
    check("R3", 32'(beat), 32'd0);
    check("R3", 32'(addr_out), 32'h1F00F);
    // R5: idle holds
    cycle(0, 0, 1, 0, 17'h00000);
    check("R5", 32'(addr_out), 32'h1F00F);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cycle(r == 4'd0, r == 4'd1 || r == 4'd2, ($urandom % 4) == 0,
            1'($urandom), 17'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule : burst_addr_seq_test